// File: doc/BRIEF.md
# Sensor Limit Comparison Unit

This block holds the alarm thresholds for a hardware monitor. Each of three temperature channels (remote 1, local, remote 2) has a programmable low threshold and a programmable high threshold. Each of four fan tachometer channels has a 16-bit threshold stored as a pair of bytes. Whenever a channel presents a fresh conversion result with its valid strobe, the block compares the result with that channel's thresholds. Any alarm is latched into one of two sticky status registers. Each status register clears when software reads it.

Software reaches the thresholds and the status registers through a simple byte-wide read/write port at fixed addresses. The configuration lock input does not protect the thresholds. One threshold byte serves two purposes. When the single-channel conversion mode input is set, the upper three bits of that byte become a converter channel select, its lower five bits become reserved, and the comparison for the first fan is suspended.

Top module: `senslim_top`

## Requirements
- R1: After reset every temperature low threshold reads 0x81, every temperature high threshold reads 0x7F, every tach threshold byte reads 0xFF, both status registers read 0x00 and adc_chan_sel is 0.
- R2: Temperature thresholds sit at 0x4E+2c (low) and 0x4F+2c (high) for channel c (0 remote 1, 1 local, 2 remote 2). Tach thresholds sit at 0x54+2k (low byte) and 0x55+2k (high byte) for fan k (0..3). Every written value reads back unchanged.
- R3: A valid temperature result that is strictly greater than its high threshold, with both treated as 8-bit two's complement, sets bit 2c+1 of the temperature status register at 0x41. An equal result does not set it.
- R4: A valid temperature result that is less than or equal to its low threshold, with both signed, sets bit 2c of the temperature status register.
- R5: A valid tach count that is greater (unsigned) than the 16-bit threshold {high byte, low byte} of fan k sets bit k of the fan status register at 0x42. A count equal to the threshold does not set it.
- R6: A result presented without its valid strobe has no effect on either status register.
- R7: Status bits are sticky. A read of 0x41 or 0x42 returns the value held before the read and clears that register on the same clock edge. An alarm arriving in the same cycle as the clearing read stays set.
- R8: Threshold writes take effect whatever the value of cfg_lock.
- R9: While sc_mode is 1, bits [7:5] of 0x55 are writable and drive adc_chan_sel, reads of 0x55 return 0 in bits [4:0], and writes leave the stored bits [4:0] unchanged. The stored bits reappear once sc_mode returns to 0, and adc_chan_sel is then 0.
- R10: While sc_mode is 1, fan 0 never sets its status bit. With sc_mode at 0 its comparison is active.
- R11: Reads of any address outside 0x41, 0x42 and 0x4E..0x5B return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears a status register that is read) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| cfg_lock | input | 1 | Configuration lock; has no effect on thresholds |
| sc_mode | input | 1 | Single-channel conversion mode |
| temp_vld | input | 3 | Per-channel temperature result strobe |
| temp_data | input | 24 | Temperature results, channel c in bits [8c+7:8c] |
| tach_vld | input | 4 | Per-fan tach count strobe |
| tach_cnt | input | 64 | Tach counts, fan k in bits [16k+15:16k] |
| adc_chan_sel | output | 3 | Converter channel selected in single-channel mode |

## Verification
Each temperature channel is swept through all 256 reading values against three threshold pairs: the reset pair, an ordinary positive window and a window whose low threshold is negative. Together these separate signed from unsigned compares, strict from non-strict compares and one channel's bits from another's. Tach counts straddle a programmed threshold at count-1, equal and count+1, and also at the extremes, so each fan's 16-bit compare and byte order are pinned down. Directed sequences cover the clear-on-read race, results offered without a strobe, and entry into and exit from single-channel mode with the reserved bits preserved.

// File: rtl/senslim_pkg.sv
package senslim_pkg;
  localparam int AW          = 8;
  localparam int DW          = 8;
  localparam int TACH_W      = 16;
  localparam int N_TEMP      = 3;
  localparam int N_TACH      = 4;
  localparam int SEL_W       = 3;
  localparam int TEMP_BASE   = 'h4E;
  localparam int TACH_BASE   = 'h54;
  localparam int STAT_T_ADDR = 'h41;
  localparam int STAT_F_ADDR = 'h42;
  localparam logic [7:0] TLO_RST  = 8'h81;
  localparam logic [7:0] THI_RST  = 8'h7F;
  localparam logic [7:0] TACH_RST = 8'hFF;
endpackage

// File: rtl/senslim_limregs.sv
module senslim_limregs
  import senslim_pkg::*;
#(
  parameter int P_AW     = AW,
  parameter int P_DW     = DW,
  parameter int P_NTEMP  = N_TEMP,
  parameter int P_NTACH  = N_TACH,
  parameter int P_SEL_W  = SEL_W
) (
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        wr_en,
  input  logic [P_AW-1:0]             addr,
  input  logic [P_DW-1:0]             wdata,
  input  logic                        sc_mode,
  output logic [P_NTEMP*P_DW-1:0]     tlo_o,
  output logic [P_NTEMP*P_DW-1:0]     thi_o,
  output logic [2*P_NTACH*P_DW-1:0]   tach_o,
  output logic                        rd_hit,
  output logic [P_DW-1:0]             rd_data,
  output logic [P_SEL_W-1:0]          adc_sel_o
);
  localparam int NT_REGS = 2 * P_NTEMP;
  localparam int NF_REGS = 2 * P_NTACH;
  localparam int SC_REG  = 1;            // tach byte index shared with channel select
  localparam int RSV_W   = P_DW - P_SEL_W;

  logic [P_DW-1:0] temp_q [NT_REGS];
  logic [P_DW-1:0] temp_d [NT_REGS];
  logic [P_DW-1:0] tach_q [NF_REGS];
  logic [P_DW-1:0] tach_d [NF_REGS];

  // next state
  always_comb begin
    for (int i = 0; i < NT_REGS; i++) begin
      temp_d[i] = temp_q[i];
      if (wr_en && (addr == P_AW'(TEMP_BASE + i))) temp_d[i] = wdata;
    end
    for (int j = 0; j < NF_REGS; j++) begin
      tach_d[j] = tach_q[j];
      if (wr_en && (addr == P_AW'(TACH_BASE + j))) begin
        if ((j == SC_REG) && sc_mode)
          tach_d[j] = {wdata[P_DW-1 -: P_SEL_W], tach_q[j][RSV_W-1:0]};
        else
          tach_d[j] = wdata;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NT_REGS; i++)
        temp_q[i] <= (i % 2 == 0) ? TLO_RST : THI_RST;
      for (int j = 0; j < NF_REGS; j++)
        tach_q[j] <= TACH_RST;
    end else begin
      for (int i = 0; i < NT_REGS; i++) temp_q[i] <= temp_d[i];
      for (int j = 0; j < NF_REGS; j++) tach_q[j] <= tach_d[j];
    end
  end

  // read side
  always_comb begin
    rd_hit  = 1'b0;
    rd_data = '0;
    for (int i = 0; i < NT_REGS; i++) begin
      if (addr == P_AW'(TEMP_BASE + i)) begin
        rd_hit  = 1'b1;
        rd_data = temp_q[i];
      end
    end
    for (int j = 0; j < NF_REGS; j++) begin
      if (addr == P_AW'(TACH_BASE + j)) begin
        rd_hit = 1'b1;
        if ((j == SC_REG) && sc_mode)
          rd_data = {tach_q[j][P_DW-1 -: P_SEL_W], {RSV_W{1'b0}}};
        else
          rd_data = tach_q[j];
      end
    end
  end

  assign adc_sel_o = sc_mode ? tach_q[SC_REG][P_DW-1 -: P_SEL_W] : '0;

  for (genvar c = 0; c < P_NTEMP; c++) begin : g_tout
    assign tlo_o[c*P_DW +: P_DW] = temp_q[2*c];
    assign thi_o[c*P_DW +: P_DW] = temp_q[2*c+1];
  end
  for (genvar j = 0; j < NF_REGS; j++) begin : g_fout
    assign tach_o[j*P_DW +: P_DW] = tach_q[j];
  end
endmodule

// File: rtl/senslim_tempcmp.sv
module senslim_tempcmp
  import senslim_pkg::*;
#(
  parameter int P_DW    = DW,
  parameter int P_NTEMP = N_TEMP
) (
  input  logic [P_NTEMP-1:0]      vld,
  input  logic [P_NTEMP*P_DW-1:0] data,
  input  logic [P_NTEMP*P_DW-1:0] lo_lim,
  input  logic [P_NTEMP*P_DW-1:0] hi_lim,
  output logic [2*P_NTEMP-1:0]    evt
);
  for (genvar c = 0; c < P_NTEMP; c++) begin : g_ch
    logic signed [P_DW-1:0] rd_s, lo_s, hi_s;
    assign rd_s = data[c*P_DW +: P_DW];
    assign lo_s = lo_lim[c*P_DW +: P_DW];
    assign hi_s = hi_lim[c*P_DW +: P_DW];
    assign evt[2*c]   = vld[c] && (rd_s <= lo_s);
    assign evt[2*c+1] = vld[c] && (rd_s >  hi_s);
  end
endmodule

// File: rtl/senslim_tachcmp.sv
module senslim_tachcmp
  import senslim_pkg::*;
#(
  parameter int P_CW    = TACH_W,
  parameter int P_NTACH = N_TACH
) (
  input  logic [P_NTACH-1:0]      vld,
  input  logic [P_NTACH*P_CW-1:0] cnt,
  input  logic [P_NTACH*P_CW-1:0] lim,
  input  logic                    sc_mode,
  output logic [P_NTACH-1:0]      evt
);
  for (genvar k = 0; k < P_NTACH; k++) begin : g_fan
    logic slow;
    assign slow = vld[k] && (cnt[k*P_CW +: P_CW] > lim[k*P_CW +: P_CW]);
    if (k == 0) begin : g_shared
      assign evt[k] = slow && !sc_mode;
    end else begin : g_plain
      assign evt[k] = slow;
    end
  end
endmodule

// File: rtl/senslim_status.sv
module senslim_status #(
  parameter int W_T = 6,
  parameter int W_F = 4
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic [W_T-1:0] set_t,
  input  logic [W_F-1:0] set_f,
  input  logic           clr_t,
  input  logic           clr_f,
  output logic [W_T-1:0] q_t,
  output logic [W_F-1:0] q_f
);
  logic [W_T-1:0] d_t;
  logic [W_F-1:0] d_f;

  // a new alarm wins over a clearing read in the same cycle
  always_comb begin
    d_t = (clr_t ? '0 : q_t) | set_t;
    d_f = (clr_f ? '0 : q_f) | set_f;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_t <= '0;
      q_f <= '0;
    end else begin
      q_t <= d_t;
      q_f <= d_f;
    end
  end
endmodule

// File: rtl/senslim_top.sv
module senslim_top
  import senslim_pkg::*;
#(
  parameter int P_AW    = AW,
  parameter int P_DW    = DW,
  parameter int P_CW    = TACH_W,
  parameter int P_NTEMP = N_TEMP,
  parameter int P_NTACH = N_TACH,
  parameter int P_SEL_W = SEL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [P_AW-1:0]            reg_addr,
  input  logic [P_DW-1:0]            reg_wdata,
  output logic [P_DW-1:0]            reg_rdata,
  input  logic                       cfg_lock,
  input  logic                       sc_mode,
  input  logic [P_NTEMP-1:0]         temp_vld,
  input  logic [P_NTEMP*P_DW-1:0]    temp_data,
  input  logic [P_NTACH-1:0]         tach_vld,
  input  logic [P_NTACH*P_CW-1:0]    tach_cnt,
  output logic [P_SEL_W-1:0]         adc_chan_sel
);
  localparam int W_T = 2 * P_NTEMP;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // the lock has no say over threshold writes
  logic lock_unused;
  assign lock_unused = cfg_lock;

  logic [P_NTEMP*P_DW-1:0] temp_lo_lim, temp_hi_lim;
  logic [P_NTACH*P_CW-1:0] tach_lim;
  logic                    lim_hit;
  logic [P_DW-1:0]         lim_rdata;
  logic [W_T-1:0]          evt_t, stat1_q;
  logic [P_NTACH-1:0]      evt_f, stat2_q;
  logic                    clr_t, clr_f;

  senslim_limregs #(
    .P_AW(P_AW), .P_DW(P_DW), .P_NTEMP(P_NTEMP), .P_NTACH(P_NTACH), .P_SEL_W(P_SEL_W)
  ) u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .sc_mode(sc_mode), .tlo_o(temp_lo_lim), .thi_o(temp_hi_lim), .tach_o(tach_lim),
    .rd_hit(lim_hit), .rd_data(lim_rdata), .adc_sel_o(adc_chan_sel)
  );

  senslim_tempcmp #(.P_DW(P_DW), .P_NTEMP(P_NTEMP)) u_tcmp (
    .vld(temp_vld), .data(temp_data), .lo_lim(temp_lo_lim), .hi_lim(temp_hi_lim), .evt(evt_t)
  );

  senslim_tachcmp #(.P_CW(P_CW), .P_NTACH(P_NTACH)) u_fcmp (
    .vld(tach_vld), .cnt(tach_cnt), .lim(tach_lim), .sc_mode(sc_mode), .evt(evt_f)
  );

  assign clr_t = reg_rd && (reg_addr == P_AW'(STAT_T_ADDR));
  assign clr_f = reg_rd && (reg_addr == P_AW'(STAT_F_ADDR));

  senslim_status #(.W_T(W_T), .W_F(P_NTACH)) u_stat (
    .clk(clk), .rst_ni(rst_ni), .set_t(evt_t), .set_f(evt_f),
    .clr_t(clr_t), .clr_f(clr_f), .q_t(stat1_q), .q_f(stat2_q)
  );

  always_comb begin
    if (reg_addr == P_AW'(STAT_T_ADDR))      reg_rdata = P_DW'(stat1_q);
    else if (reg_addr == P_AW'(STAT_F_ADDR)) reg_rdata = P_DW'(stat2_q);
    else if (lim_hit)                        reg_rdata = lim_rdata;
    else                                     reg_rdata = '0;
  end
endmodule

// File: rtl/senslim_chk.sv
module senslim_chk #(
  parameter int P_AW    = 8,
  parameter int P_DW    = 8,
  parameter int P_CW    = 16,
  parameter int P_NTEMP = 3,
  parameter int P_NTACH = 4
) (
  input logic                    clk,
  input logic                    rst_ni,
  input logic                    reg_wr,
  input logic                    reg_rd,
  input logic [P_AW-1:0]         reg_addr,
  input logic [P_DW-1:0]         reg_wdata,
  input logic                    sc_mode,
  input logic [P_NTEMP-1:0]      temp_vld,
  input logic [P_NTEMP*P_DW-1:0] temp_data,
  input logic [P_NTACH-1:0]      tach_vld,
  input logic [P_NTACH*P_CW-1:0] tach_cnt,
  input logic [P_NTEMP*P_DW-1:0] temp_lo_lim,
  input logic [P_NTEMP*P_DW-1:0] temp_hi_lim,
  input logic [P_NTACH*P_CW-1:0] tach_lim,
  input logic [2*P_NTEMP-1:0]    stat1_q,
  input logic [P_NTACH-1:0]      stat2_q
);
  logic rd_t, rd_f;
  assign rd_t = reg_rd && (reg_addr == P_AW'('h41));
  assign rd_f = reg_rd && (reg_addr == P_AW'('h42));

  for (genvar c = 0; c < P_NTEMP; c++) begin : g_t
    assert_hi_set_R3: assert property (@(posedge clk) disable iff (!rst_ni)
      (temp_vld[c] && ($signed(temp_data[c*P_DW +: P_DW]) > $signed(temp_hi_lim[c*P_DW +: P_DW])))
      |=> stat1_q[2*c+1]);
    assert_lo_set_R4: assert property (@(posedge clk) disable iff (!rst_ni)
      (temp_vld[c] && ($signed(temp_data[c*P_DW +: P_DW]) <= $signed(temp_lo_lim[c*P_DW +: P_DW])))
      |=> stat1_q[2*c]);
  end

  for (genvar k = 1; k < P_NTACH; k++) begin : g_f
    assert_fan_slow_R5: assert property (@(posedge clk) disable iff (!rst_ni)
      (tach_vld[k] && (tach_cnt[k*P_CW +: P_CW] > tach_lim[k*P_CW +: P_CW])) |=> stat2_q[k]);
  end

  assert_sticky_temp_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_t |=> ((stat1_q & $past(stat1_q)) == $past(stat1_q)));
  assert_sticky_fan_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_f |=> ((stat2_q & $past(stat2_q)) == $past(stat2_q)));

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_wr && (reg_addr == P_AW'('h4E))) |=> (temp_lo_lim[P_DW-1:0] == $past(reg_wdata)));

  assert_rsv_kept_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (sc_mode && reg_wr && (reg_addr == P_AW'('h55))) |=> (tach_lim[P_DW +: 5] == $past(tach_lim[P_DW +: 5])));

  assert_fan0_quiet_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (sc_mode && !stat2_q[0]) |=> !stat2_q[0]);
endmodule

bind senslim_top senslim_chk #(
  .P_AW(P_AW), .P_DW(P_DW), .P_CW(P_CW), .P_NTEMP(P_NTEMP), .P_NTACH(P_NTACH)
) u_chk (
  .clk(clk), .rst_ni(rst_ni), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sc_mode(sc_mode), .temp_vld(temp_vld), .temp_data(temp_data),
  .tach_vld(tach_vld), .tach_cnt(tach_cnt), .temp_lo_lim(temp_lo_lim),
  .temp_hi_lim(temp_hi_lim), .tach_lim(tach_lim), .stat1_q(stat1_q), .stat2_q(stat2_q)
);

// File: tb/senslim_top_bench.sv
`timescale 1ns/1ps
module senslim_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr, reg_wdata, reg_rdata;
  logic        cfg_lock, sc_mode;
  logic [2:0]  temp_vld;
  logic [23:0] temp_data;
  logic [3:0]  tach_vld;
  logic [63:0] tach_cnt;
  logic [2:0]  adc_chan_sel;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  senslim_top u_senslim_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_lock(cfg_lock), .sc_mode(sc_mode),
    .temp_vld(temp_vld), .temp_data(temp_data), .tach_vld(tach_vld), .tach_cnt(tach_cnt),
    .adc_chan_sel(adc_chan_sel)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic tstrobe(int c, logic [7:0] v);
    @(negedge clk); temp_data[c*8 +: 8] = v; temp_vld[c] = 1'b1;
    @(negedge clk); temp_vld = '0;
  endtask

  task automatic fstrobe(int k, logic [15:0] v);
    @(negedge clk); tach_cnt[k*16 +: 16] = v; tach_vld[k] = 1'b1;
    @(negedge clk); tach_vld = '0;
  endtask

  task automatic temp_sweep(int c, logic [7:0] lo, logic [7:0] hi);
    logic [7:0] d;
    wr(8'(8'h4E + 2*c), lo);
    wr(8'(8'h4F + 2*c), hi);
    for (int v = 0; v < 256; v++) begin
      int sv, sl, sh;
      logic [7:0] exp;
      sv = $signed(8'(v)); sl = $signed(lo); sh = $signed(hi);
      exp = '0;
      exp[2*c]   = (sv <= sl);   // R4
      exp[2*c+1] = (sv >  sh);   // R3
      tstrobe(c, 8'(v));
      rd(8'h41, d);
      check("R3/R4 temp compare", {8'h0, d}, {8'h0, exp});
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic [15:0] counts [7];
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    cfg_lock = 0; sc_mode = 0; temp_vld = 0; temp_data = 0; tach_vld = 0; tach_cnt = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    for (int a = 8'h4E; a <= 8'h53; a++) begin
      rd(8'(a), d);
      check("R1 temp reset", {8'h0, d}, (a % 2 == 0) ? 16'h81 : 16'h7F);
    end
    for (int a = 8'h54; a <= 8'h5B; a++) begin
      rd(8'(a), d);
      check("R1 tach reset", {8'h0, d}, 16'hFF);
    end
    rd(8'h41, d); check("R1 stat1 reset", {8'h0, d}, 16'h0);
    rd(8'h42, d); check("R1 stat2 reset", {8'h0, d}, 16'h0);
    check("R1 adc_chan_sel reset", {13'h0, adc_chan_sel}, 16'h0);

    // R5 boundary at default threshold: count equal to 0xFFFF is not slow
    for (int k = 0; k < 4; k++) fstrobe(k, 16'hFFFF);
    rd(8'h42, d); check("R5 equal to default limit", {8'h0, d}, 16'h0);

    // R3/R4 sweeps: reset pair, positive window, window with negative low
    for (int c = 0; c < 3; c++) begin
      temp_sweep(c, 8'h81, 8'h7F);
      temp_sweep(c, 8'h10, 8'h20);
      temp_sweep(c, 8'hF0, 8'h05);
    end

    // R2 readback of programmed temp limits
    rd(8'h52, d); check("R2 remote2 low readback", {8'h0, d}, 16'hF0);
    rd(8'h53, d); check("R2 remote2 high readback", {8'h0, d}, 16'h05);

    // R5 tach sweeps around 0x1234 (low byte 0x34, high byte 0x12)
    counts = '{16'h0000, 16'h1233, 16'h1234, 16'h1235, 16'h1300, 16'h1134, 16'hFFFF};
    for (int k = 0; k < 4; k++) begin
      wr(8'(8'h54 + 2*k), 8'h34);
      wr(8'(8'h55 + 2*k), 8'h12);
      rd(8'(8'h54 + 2*k), d); check("R2 tach low readback", {8'h0, d}, 16'h34);
      rd(8'(8'h55 + 2*k), d); check("R2 tach high readback", {8'h0, d}, 16'h12);
      for (int i = 0; i < 7; i++) begin
        fstrobe(k, counts[i]);
        rd(8'h42, d);
        check("R5 tach compare", {8'h0, d},
              (counts[i] > 16'h1234) ? 16'(1 << k) : 16'h0);
      end
    end

    // R6 no strobe, no alarm
    wr(8'h4E, 8'h81); wr(8'h4F, 8'h00);
    @(negedge clk); temp_data = 24'h7F7F7F; tach_cnt = '1;
    repeat (3) @(negedge clk);
    rd(8'h41, d); check("R6 temp without strobe", {8'h0, d}, 16'h0);
    rd(8'h42, d); check("R6 tach without strobe", {8'h0, d}, 16'h0);

    // R7 sticky and clear on read
    tstrobe(0, 8'h40);
    tstrobe(0, 8'h00);
    rd(8'h41, d); check("R7 sticky after quiet result", {8'h0, d}, 16'h02);
    rd(8'h41, d); check("R7 cleared by read", {8'h0, d}, 16'h0);
    // alarm in the same cycle as the clearing read
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 8'h41; temp_data[7:0] = 8'h40; temp_vld[0] = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0; temp_vld = '0;
    check("R7 read before race value", {8'h0, d}, 16'h0);
    rd(8'h41, d); check("R7 set wins over clear", {8'h0, d}, 16'h02);

    // R8 lock does not block threshold writes
    cfg_lock = 1'b1;
    wr(8'h50, 8'h33); rd(8'h50, d); check("R8 temp write under lock", {8'h0, d}, 16'h33);
    wr(8'h5A, 8'h77); rd(8'h5A, d); check("R8 tach write under lock", {8'h0, d}, 16'h77);
    cfg_lock = 1'b0;

    // R9 / R10 single-channel mode (0x55 holds 0x12, 0x54 holds 0x34)
    @(negedge clk); sc_mode = 1'b1;
    rd(8'h55, d); check("R9 reserved bits read zero", {8'h0, d}, 16'h00);
    wr(8'h55, 8'hBF);
    rd(8'h55, d); check("R9 select readback", {8'h0, d}, 16'hA0);
    check("R9 adc_chan_sel", {13'h0, adc_chan_sel}, 16'h5);
    fstrobe(0, 16'hFFFF);
    rd(8'h42, d); check("R10 fan0 suppressed", {8'h0, d}, 16'h0);
    fstrobe(1, 16'hFFFF);
    rd(8'h42, d); check("R10 other fans still active", {8'h0, d}, 16'h2);
    @(negedge clk); sc_mode = 1'b0;
    rd(8'h55, d); check("R9 reserved bits preserved", {8'h0, d}, 16'hB2);
    check("R9 adc_chan_sel idle", {13'h0, adc_chan_sel}, 16'h0);
    fstrobe(0, 16'hB235);
    rd(8'h42, d); check("R10 fan0 active again", {8'h0, d}, 16'h1);
    fstrobe(0, 16'hB234);
    rd(8'h42, d); check("R10 fan0 equal not slow", {8'h0, d}, 16'h0);

    // R11 unmapped reads
    rd(8'h40, d); check("R11 unmapped 0x40", {8'h0, d}, 16'h0);
    rd(8'h4D, d); check("R11 unmapped 0x4D", {8'h0, d}, 16'h0);
    rd(8'h5C, d); check("R11 unmapped 0x5C", {8'h0, d}, 16'h0);

    summary();
  end
endmodule